// File: doc/BRIEF.md
# Stream Broadcast Fan-Out

This block accepts one valid/ready stream of signed 16-bit samples and copies every accepted word to a set of parallel consumer channels. Each consumer receives the identical sequence, in the order the producer sent it. Each consumer channel has a small FIFO. This lets consumers drain at different rates over short spans. A word leaves the producer only when every channel FIFO can take it. A single slow or halted consumer therefore holds back the producer, and through it all the other consumers, until that consumer drains.

A run begins with a one-cycle start pulse that carries the number of words to broadcast. The block then accepts exactly that many words, drops its input ready, and raises a one-cycle done flag. Start pulses that arrive while a run is active have no effect.

Top module: `bcast_fanout`

## Requirements
- R1: While reset is held and just after it is released, `in_ready_o`, `busy_o`, `done_o` and every bit of `out_valid_o` are 0.
- R2: A start pulse seen while idle with a nonzero count sets `busy_o` from the next cycle. While busy, `in_ready_o` is 1 whenever no channel FIFO is full.
- R3: Every accepted input word appears unchanged on every channel, in acceptance order. Channel c carries its word on `out_data_o[c*DATA_W +: DATA_W]`. A word offered but not taken stays stable.
- R4: A run with count N accepts exactly N input words. Outside a run, `in_ready_o` stays 0.
- R5: `done_o` is high for exactly one cycle per run, in the cycle after the final word is accepted. `busy_o` is 0 in that same cycle.
- R6: If any one channel FIFO is full, `in_ready_o` is 0. A stalled consumer therefore stops the producer and every other channel from receiving further words.
- R7: A start pulse while `busy_o` is 1 is ignored: the run still ends after its original count.
- R8: A start with count 0 accepts no word, never sets `busy_o`, and gives a `done_o` pulse in the next cycle.
- R9: Each channel holds up to FIFO_DEPTH (default 8) words that its consumer has not yet taken. `out_valid_o[c]` is 1 exactly when channel c holds at least one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a run |
| count_i | input | CNT_W | Number of words to broadcast, sampled with start_i |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse after the last word of a run |
| in_data_i | input | DATA_W | Signed input sample |
| in_valid_i | input | 1 | Producer offers a sample |
| in_ready_o | output | 1 | Block takes the sample this cycle |
| out_data_o | output | NUM_CH*DATA_W | Per-channel output sample, channel c in slice c |
| out_valid_o | output | NUM_CH | Channel c holds a word for its consumer |
| out_ready_i | input | NUM_CH | Consumer c takes its word this cycle |

## Verification
The hardest situation to reach is one channel filling its FIFO while the others keep draining. The producer must halt at exactly FIFO_DEPTH words, and the free consumers must receive nothing more. The stimulus holds one consumer's ready low for a long stretch while the producer offers words continuously. It then checks the word counts on every channel before releasing that consumer. Periodic ready patterns that differ per channel, together with gaps in the producer's valid, move the full condition between channels and cycles during ordinary runs.

// File: rtl/bcast_pkg.sv
// Shared types for the broadcast fan-out.
// Assumes nothing beyond standard SystemVerilog packages.
package bcast_pkg;

    // Run controller states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

endpackage

// File: rtl/bcast_fifo.sv
// Single-clock FIFO that sits between the broadcaster and one consumer.
// Assumes the writer never pushes while full_o is high; a push in that
// state is dropped. DEPTH must be at least 2.
module bcast_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    output logic         full_o,
    output logic [W-1:0] rd_data_o,
    output logic         rd_valid_o,
    input  logic         rd_ready_i
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] occ;
    logic          do_push;
    logic          do_pop;

    assign full_o     = (occ == FULL_CNT);
    assign rd_valid_o = (occ != '0);
    assign rd_data_o  = mem[rd_ptr];
    assign do_push    = push_i && !full_o;
    assign do_pop     = rd_ready_i && rd_valid_o;

    // Storage write: data lands at the write pointer
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data_i;
        end
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

endmodule

// File: rtl/bcast_ctrl.sv
// Run controller: loads the word count on a start pulse taken while idle,
// counts accepted words down, and pulses done after the final one.
// Assumes accept_i is high only while busy_o is high.
module bcast_ctrl
    import bcast_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             accept_i,
    output logic             busy_o,
    output logic             done_o
);
    run_state_t       state;
    logic [CNT_W-1:0] remain;

    assign busy_o = (state == ST_RUN);

    // Run sequencing and remaining-word count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            remain <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        if (count_i == '0) begin
                            done_o <= 1'b1;
                        end else begin
                            remain <= count_i;
                            state  <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (accept_i) begin
                        remain <= remain - 1'b1;
                        if (remain == CNT_W'(1)) begin
                            state  <= ST_IDLE;
                            done_o <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bcast_fanout.sv
// Broadcast fan-out: one valid/ready input stream copied to NUM_CH output
// streams, each with its own FIFO. A word is accepted only when every FIFO
// has room, so any stalled consumer halts the producer and all channels.
// Assumes consumers follow valid/ready rules on their own channel.
module bcast_fanout #(
    parameter int DATA_W     = 16,
    parameter int NUM_CH     = 2,
    parameter int FIFO_DEPTH = 8,
    parameter int CNT_W      = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [CNT_W-1:0]         count_i,
    output logic                     busy_o,
    output logic                     done_o,
    input  logic [DATA_W-1:0]        in_data_i,
    input  logic                     in_valid_i,
    output logic                     in_ready_o,
    output logic [NUM_CH*DATA_W-1:0] out_data_o,
    output logic [NUM_CH-1:0]        out_valid_o,
    input  logic [NUM_CH-1:0]        out_ready_i
);
    logic [NUM_CH-1:0] ch_full;
    logic              accept;

    // Joint backpressure: take a word only when every channel has room
    assign in_ready_o = busy_o && (ch_full == '0);
    assign accept     = in_valid_i && in_ready_o;

    bcast_ctrl #(
        .CNT_W (CNT_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .count_i  (count_i),
        .accept_i (accept),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    // One FIFO per consumer channel, all written by the same accept
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        bcast_fifo #(
            .W     (DATA_W),
            .DEPTH (FIFO_DEPTH)
        ) fifo_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .push_i      (accept),
            .push_data_i (in_data_i),
            .full_o      (ch_full[c]),
            .rd_data_o   (out_data_o[c*DATA_W +: DATA_W]),
            .rd_valid_o  (out_valid_o[c]),
            .rd_ready_i  (out_ready_i[c])
        );
    end

endmodule

// File: rtl/bcast_fanout_chk.sv
// Property checker for the broadcast fan-out. It keeps its own per-channel
// occupancy count from the port handshakes and checks it against the outputs.
module bcast_fanout_chk #(
    parameter int DATA_W = 16,
    parameter int NUM_CH = 2,
    parameter int DEPTH  = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     busy_o,
    input logic                     done_o,
    input logic                     in_valid_i,
    input logic                     in_ready_o,
    input logic [NUM_CH*DATA_W-1:0] out_data_o,
    input logic [NUM_CH-1:0]        out_valid_o,
    input logic [NUM_CH-1:0]        out_ready_i
);
    localparam int CW = $clog2(DEPTH + 2);

    logic accept;
    assign accept = in_valid_i && in_ready_o;

    AST_NO_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> busy_o); // R4

    AST_DONE_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R5

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R5

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        logic [CW-1:0] occ;

        // Shadow occupancy from the handshakes at the ports
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                occ <= '0;
            end else begin
                occ <= occ + CW'(accept) - CW'(out_valid_o[c] && out_ready_i[c]);
            end
        end

        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            accept |-> (occ < CW'(DEPTH))); // R6

        AST_VALID_MATCHES_OCC: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid_o[c] == (occ != '0)); // R9

        AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid_o[c] && !out_ready_i[c]) |=>
                (out_valid_o[c] && $stable(out_data_o[c*DATA_W +: DATA_W]))); // R3
    end

endmodule

bind bcast_fanout bcast_fanout_chk #(
    .DATA_W (DATA_W),
    .NUM_CH (NUM_CH),
    .DEPTH  (FIFO_DEPTH)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .out_data_o  (out_data_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i)
);

// File: tb/bcast_fanout_tb_top.sv
// Bench for the broadcast fan-out: table-driven runs, then directed cases.
module bcast_fanout_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int NUM_CH     = 2;
    localparam int DEPTH      = 8;
    localparam int CNT_W      = 16;
    localparam int NVEC       = 6;

    // {count[47:32], seed[31:16], ready mode[15:8], valid mode[7:0]}
    localparam logic [47:0] VEC_TAB [NVEC] = '{
        {16'd5,  16'h0010, 8'd0, 8'd0},
        {16'd20, 16'h8000, 8'd1, 8'd0},
        {16'd17, 16'h7ff0, 8'd2, 8'd1},
        {16'd30, 16'hfff0, 8'd3, 8'd0},
        {16'd1,  16'h1234, 8'd1, 8'd1},
        {16'd40, 16'h0001, 8'd2, 8'd1}
    };

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     start_i = 1'b0;
    logic [CNT_W-1:0]         count_i = '0;
    logic                     busy_o;
    logic                     done_o;
    logic [DATA_W-1:0]        in_data_i = '0;
    logic                     in_valid_i = 1'b0;
    logic                     in_ready_o;
    logic [NUM_CH*DATA_W-1:0] out_data_o;
    logic [NUM_CH-1:0]        out_valid_o;
    logic [NUM_CH-1:0]        out_ready_i = '0;

    bcast_fanout #(
        .DATA_W(DATA_W), .NUM_CH(NUM_CH), .FIFO_DEPTH(DEPTH), .CNT_W(CNT_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
        .busy_o(busy_o), .done_o(done_o), .in_data_i(in_data_i),
        .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
        .out_data_o(out_data_o), .out_valid_o(out_valid_o),
        .out_ready_i(out_ready_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Port monitor, sampled at the falling edge
    logic [DATA_W-1:0] rx [NUM_CH][64];
    int rx_n [NUM_CH];
    int acc_n, done_n, busy_at_done;

    always @(negedge clk) begin
        if (rst_n) begin
            if (in_valid_i && in_ready_o) acc_n++;
            for (int c = 0; c < NUM_CH; c++) begin
                if (out_valid_o[c] && out_ready_i[c]) begin
                    if (rx_n[c] < 64) rx[c][rx_n[c]] = out_data_o[c*DATA_W +: DATA_W];
                    rx_n[c]++;
                end
            end
            if (done_o) begin
                done_n++;
                if (busy_o) busy_at_done++;
            end
        end
    end

    // Consumer ready patterns, driven just after the rising edge
    int cyc = 0;
    int rmode = 0;
    always @(posedge clk) begin
        #1;
        cyc++;
        case (rmode)
            1:       out_ready_i = {(cyc % 4 == 0), 1'b1};
            2:       out_ready_i = {(cyc % 3 == 0), (cyc % 2 == 0)};
            3:       out_ready_i = {((cyc % 32) >= 20), 1'b1};
            4:       out_ready_i = 2'b01;
            default: out_ready_i = 2'b11;
        endcase
    end

    task automatic clear_mon();
        acc_n = 0; done_n = 0; busy_at_done = 0;
        for (int c = 0; c < NUM_CH; c++) rx_n[c] = 0;
    endtask

    task automatic do_start(input int n);
        @(posedge clk); #2;
        start_i = 1'b1; count_i = CNT_W'(n);
        @(posedge clk); #2;
        start_i = 1'b0;
    endtask

    task automatic send(input int n, input logic [15:0] seed, input int vm);
        int idx = 0;
        int guard = 0;
        while (idx < n && guard < 5000) begin
            @(posedge clk); #2;
            in_valid_i = (vm == 0) || (cyc % 3 != 0);
            in_data_i  = seed + 16'(idx * 37);
            @(negedge clk);
            if (in_valid_i && in_ready_o) idx++;
            guard++;
        end
        @(posedge clk); #2;
        in_valid_i = 1'b0;
    endtask

    task automatic drain();
        int g = 0;
        while (out_valid_o != '0 && g < 2000) begin
            @(negedge clk);
            g++;
        end
        repeat (3) @(negedge clk);
    endtask

    function automatic int bad_words(input int c, input int n, input logic [15:0] seed);
        int bad = 0;
        for (int i = 0; i < n && i < 64; i++) begin
            if (rx[c][i] !== seed + 16'(i * 37)) bad++;
        end
        return bad;
    endfunction

    task automatic check_run(input int n, input logic [15:0] seed);
        check(acc_n == n, "R4", "accepted words", acc_n, n);
        check(done_n == 1, "R5", "done pulses", done_n, 1);
        check(busy_at_done == 0, "R5", "busy during done", busy_at_done, 0);
        for (int c = 0; c < NUM_CH; c++) begin
            check(rx_n[c] == n, "R3", $sformatf("ch%0d word count", c), rx_n[c], n);
            check(bad_words(c, n, seed) == 0, "R3", $sformatf("ch%0d bad words", c),
                  bad_words(c, n, seed), 0);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check(in_ready_o == 1'b0 && busy_o == 1'b0, "R1", "ready/busy in reset",
              int'({in_ready_o, busy_o}), 0);
        check(out_valid_o == '0 && done_o == 1'b0, "R1", "valid/done in reset",
              int'({out_valid_o, done_o}), 0);
        @(posedge clk); #2; rst_n = 1'b1;
        @(negedge clk);
        check(in_ready_o == 1'b0 && out_valid_o == '0, "R1", "quiet after reset",
              int'({in_ready_o, out_valid_o}), 0);

        // Table-driven runs
        for (int v = 0; v < NVEC; v++) begin
            int n;
            logic [15:0] seed;
            n     = int'(VEC_TAB[v][47:32]);
            seed  = VEC_TAB[v][31:16];
            rmode = int'(VEC_TAB[v][15:8]);
            clear_mon();
            do_start(n);
            send(n, seed, int'(VEC_TAB[v][7:0]));
            drain();
            check_run(n, seed);
        end
        rmode = 0;

        // R2: busy and ready one cycle after start
        clear_mon();
        @(posedge clk); #2; start_i = 1'b1; count_i = 16'd3;
        @(posedge clk); #2; start_i = 1'b0;
        @(negedge clk);
        check(busy_o == 1'b1, "R2", "busy after start", int'(busy_o), 1);
        check(in_ready_o == 1'b1, "R2", "ready while busy", int'(in_ready_o), 1);
        send(3, 16'h4000, 0);
        drain();
        check_run(3, 16'h4000);

        // R8: zero count
        clear_mon();
        @(posedge clk); #2; start_i = 1'b1; count_i = '0; in_valid_i = 1'b1;
        @(posedge clk); #2; start_i = 1'b0;
        @(negedge clk);
        check(done_o == 1'b1 && busy_o == 1'b0, "R8", "done without busy",
              int'({done_o, busy_o}), 2);
        @(negedge clk);
        check(done_o == 1'b0, "R8", "done single cycle", int'(done_o), 0);
        check(in_ready_o == 1'b0 && acc_n == 0, "R8", "no words taken", acc_n, 0);
        @(posedge clk); #2; in_valid_i = 1'b0;

        // R7: start mid-run is ignored
        clear_mon();
        do_start(5);
        fork
            send(5, 16'h2200, 0);
            begin
                repeat (2) @(posedge clk);
                #3; start_i = 1'b1; count_i = 16'd20;
                @(posedge clk); #3; start_i = 1'b0;
            end
        join
        @(posedge clk); #2; in_valid_i = 1'b1;
        repeat (4) @(negedge clk);
        @(posedge clk); #2; in_valid_i = 1'b0;
        drain();
        check(acc_n == 5, "R7", "words after ignored start", acc_n, 5);
        check(busy_o == 1'b0, "R7", "run ended", int'(busy_o), 0);

        // R6 and R9: one stalled consumer halts everything at FIFO depth
        clear_mon();
        rmode = 4;
        do_start(12);
        fork
            send(12, 16'h0c00, 0);
            begin
                repeat (30) @(negedge clk);
                check(in_ready_o == 1'b0, "R6", "ready low with full channel",
                      int'(in_ready_o), 0);
                check(acc_n == DEPTH, "R9", "words held by stalled channel", acc_n, DEPTH);
                check(rx_n[0] == DEPTH, "R6", "free channel stopped", rx_n[0], DEPTH);
                check(rx_n[1] == 0 && out_valid_o[1] == 1'b1, "R9", "stalled channel holds",
                      rx_n[1], 0);
                rmode = 0;
            end
        join
        drain();
        check_run(12, 16'h0c00);

        summary();
        $finish;
    end

endmodule